// File: doc/BRIEF.md
# Bit-sliced pipelined word adder/subtractor

The block holds a small array of K-bit words and combines two of them column by column. One row is fetched on a "false" read port and another on a "true" read port. Every column computes a half sum and an inverted half carry (or half borrow) in the first cycle, and those values are registered. In the second cycle the carry or borrow ripples from the least significant column to the most significant one through a chain of two NAND stages per column, and the resolved carries are registered. In the third cycle each column forms its final bit from its half sum and its incoming carry, and the word is written back into a destination row of the same array.

A mode input selects add or subtract. A constant-one option replaces the true-port operand with the value 1, which gives increment and decrement. A new operation can be issued every cycle, and up to three operations are in flight at once. A load port writes words into the array and a peek port reads any row, so operands can be placed and results can be seen.

Top module: `bitslice_addsub`

## Requirements
- R1: While rst_ni is low and after it rises, done_o is 0 and every array row reads 0 on peek_data_o.
- R2: An issue with add_en_i=1 produces res_o = (F + T) mod 2^K and flag_o = carry out of the most significant column, where F is the row at src_f_i and T is the row at src_t_i. The carry into the least significant column is 0.
- R3: An issue with add_en_i=0 produces res_o = (F - T) mod 2^K and flag_o = 1 exactly when F < T as unsigned numbers (borrow out). The least significant column starts with no borrow.
- R4: With const_one_i=1 the true-port operand is the value 1 and src_t_i has no effect. add_en_i=1 gives increment and add_en_i=0 gives decrement, and flag_o behaves as in R2 and R3.
- R5: An operation sampled with issue_i=1 at a clock edge raises done_o with its result after the third edge from that one, and never earlier. On that same edge the result is written into row dst_i, so peek_data_o shows it from then on.
- R6: An operation can be issued on every cycle without any stall, and results come out in issue order, one per cycle.
- R7: Operands are read from the array when the operation is issued, and results are not forwarded. An operation issued on any of the three edges up to and including the write-back edge of an earlier operation sees the old row contents. An operation issued on a later edge sees the new contents.
- R8: src_f_i and src_t_i may name the same row. Subtracting a row from itself gives 0 with flag_o=0.
- R9: load_en_i writes load_data_i into row load_row_i at the clock edge. If a write-back targets the same row on the same edge, the write-back value is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Start an operation this cycle |
| add_en_i | input | 1 | 1 = add, 0 = subtract |
| const_one_i | input | 1 | Use constant 1 as the true-port operand |
| src_f_i | input | ADDR_W | Row read on the false port (minuend / first addend) |
| src_t_i | input | ADDR_W | Row read on the true port (subtrahend / second addend) |
| dst_i | input | ADDR_W | Row that receives the result |
| load_en_i | input | 1 | Write a word into the array |
| load_row_i | input | ADDR_W | Row written by the load port |
| load_data_i | input | WORD_W | Data written by the load port |
| peek_row_i | input | ADDR_W | Row shown on peek_data_o |
| peek_data_o | output | WORD_W | Current contents of the peek row |
| done_o | output | 1 | A result is present on res_o and flag_o |
| res_o | output | WORD_W | Result word of the completing operation |
| flag_o | output | 1 | Carry out (add) or borrow out (subtract) |

## Verification
Directed words set the carry and borrow chain across its full width. All-ones plus one and zero minus one ripple through every column, while 0x80 minus 0x7F and row-minus-itself tell a long borrow apart from none at all. Increment and decrement are run with a changing src_t_i to show that the true port is bypassed. A run of back-to-back issues that read a row one, two and three cycles after a pending write separates operand capture at issue from forwarding. A load that meets a write-back on the same row shows which of the two wins. Constrained random streams then mix every mode, issue gaps and unrelated loads, and a pipeline model in the bench, built from the requirements, checks each result.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic {
    MODE_SUB = 1'b0,
    MODE_ADD = 1'b1
  } mode_e;

  // propagate term of a column: add passes on A^B, subtract passes on ~(A^B)
  function automatic logic prop_sel(mode_e m, logic hs);
    return (m == MODE_ADD) ? hs : ~hs;
  endfunction
endpackage

// File: rtl/bsa_array.sv
module bsa_array #(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 4,
  localparam int ROWS = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rf_row_i,
  output logic [WORD_W-1:0] rf_data_o,
  input  logic [ADDR_W-1:0] rt_row_i,
  output logic [WORD_W-1:0] rt_data_o,
  input  logic [ADDR_W-1:0] pk_row_i,
  output logic [WORD_W-1:0] pk_data_o,
  input  logic              wb_en_i,
  input  logic [ADDR_W-1:0] wb_row_i,
  input  logic [WORD_W-1:0] wb_data_i,
  input  logic              ld_en_i,
  input  logic [ADDR_W-1:0] ld_row_i,
  input  logic [WORD_W-1:0] ld_data_i
);
  logic [WORD_W-1:0] mem_q [ROWS];
  logic              live_q;

  assign rf_data_o = mem_q[rf_row_i];
  assign rt_data_o = mem_q[rt_row_i];
  assign pk_data_o = mem_q[pk_row_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) mem_q[r] <= '0;
    end else begin
      if (ld_en_i) mem_q[ld_row_i] <= ld_data_i;
      if (wb_en_i) mem_q[wb_row_i] <= wb_data_i;  // write-back wins
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  // R9: write-back value survives a same-row load
  a_r9_wb_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q && $past(wb_en_i && ld_en_i && (wb_row_i == ld_row_i))
    |-> mem_q[$past(wb_row_i)] == $past(wb_data_i));
endmodule

// File: rtl/bsa_col.sv
module bsa_col (
  input  logic a_i,
  input  logic b_i,
  input  logic sub_i,
  output logic hs_o,
  output logic ncy_o
);
  logic a_eff;
  assign a_eff = sub_i ? ~a_i : a_i;
  assign hs_o  = a_i ^ b_i;
  assign ncy_o = ~(a_eff & b_i);  // inverted generate: NAND form
endmodule

// File: rtl/bsa_ripple.sv
module bsa_ripple
  import bsa_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic [WORD_W-1:0] hs_i,
  input  logic [WORD_W-1:0] ncy_i,
  input  mode_e             mode_i,
  output logic [WORD_W-1:0] cin_o,
  output logic              cout_o
);
  wire [WORD_W:0] chain;

  assign chain[0] = 1'b0;  // no carry / no borrow into LSB

  for (genvar j = 0; j < WORD_W; j++) begin : g_link
    logic np;
    assign np          = ~(prop_sel(mode_i, hs_i[j]) & chain[j]);
    assign chain[j+1]  = ~(ncy_i[j] & np);
  end

  assign cin_o  = chain[WORD_W-1:0];
  assign cout_o = chain[WORD_W];
endmodule

// File: rtl/bsa_merge.sv
module bsa_merge #(
  parameter int WORD_W = 8
) (
  input  logic [WORD_W-1:0] hs_i,
  input  logic [WORD_W-1:0] cin_i,
  output logic [WORD_W-1:0] sum_o
);
  for (genvar j = 0; j < WORD_W; j++) begin : g_bit
    assign sum_o[j] = hs_i[j] ^ cin_i[j];
  end
endmodule

// File: rtl/bitslice_addsub.sv
module bitslice_addsub
  import bsa_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_i,
  input  logic              add_en_i,
  input  logic              const_one_i,
  input  logic [ADDR_W-1:0] src_f_i,
  input  logic [ADDR_W-1:0] src_t_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic              load_en_i,
  input  logic [ADDR_W-1:0] load_row_i,
  input  logic [WORD_W-1:0] load_data_i,
  input  logic [ADDR_W-1:0] peek_row_i,
  output logic [WORD_W-1:0] peek_data_o,
  output logic              done_o,
  output logic [WORD_W-1:0] res_o,
  output logic              flag_o
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  logic [WORD_W-1:0] op_f, op_t_raw, op_t;
  logic [WORD_W-1:0] hs_c, ncy_c;
  mode_e             mode_c;

  // stage 1: half results
  logic              s1_vld;
  mode_e             s1_mode;
  logic [ADDR_W-1:0] s1_dst;
  logic [WORD_W-1:0] s1_hs, s1_ncy;

  // stage 2: resolved carries
  logic [WORD_W-1:0] cin_c;
  logic              cout_c;
  logic              s2_vld;
  logic [ADDR_W-1:0] s2_dst;
  logic [WORD_W-1:0] s2_hs, s2_cin;
  logic              s2_cout;

  // stage 3: final word
  logic [WORD_W-1:0] sum_c;
  logic              done_q, flag_q;
  logic [WORD_W-1:0] res_q;

  bsa_array #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rf_row_i (src_f_i),
    .rf_data_o(op_f),
    .rt_row_i (src_t_i),
    .rt_data_o(op_t_raw),
    .pk_row_i (peek_row_i),
    .pk_data_o(peek_data_o),
    .wb_en_i  (s2_vld),
    .wb_row_i (s2_dst),
    .wb_data_i(sum_c),
    .ld_en_i  (load_en_i),
    .ld_row_i (load_row_i),
    .ld_data_i(load_data_i)
  );

  assign op_t   = const_one_i ? ONE : op_t_raw;
  assign mode_c = add_en_i ? MODE_ADD : MODE_SUB;

  for (genvar j = 0; j < WORD_W; j++) begin : g_col
    bsa_col u_col (
      .a_i  (op_f[j]),
      .b_i  (op_t[j]),
      .sub_i(~add_en_i),
      .hs_o (hs_c[j]),
      .ncy_o(ncy_c[j])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_mode <= MODE_ADD;
      s1_dst  <= '0;
      s1_hs   <= '0;
      s1_ncy  <= '1;
    end else begin
      s1_vld <= issue_i;
      if (issue_i) begin
        s1_mode <= mode_c;
        s1_dst  <= dst_i;
        s1_hs   <= hs_c;
        s1_ncy  <= ncy_c;
      end
    end
  end

  bsa_ripple #(.WORD_W(WORD_W)) u_ripple (
    .hs_i  (s1_hs),
    .ncy_i (s1_ncy),
    .mode_i(s1_mode),
    .cin_o (cin_c),
    .cout_o(cout_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld  <= 1'b0;
      s2_dst  <= '0;
      s2_hs   <= '0;
      s2_cin  <= '0;
      s2_cout <= 1'b0;
    end else begin
      s2_vld <= s1_vld;
      if (s1_vld) begin
        s2_dst  <= s1_dst;
        s2_hs   <= s1_hs;
        s2_cin  <= cin_c;
        s2_cout <= cout_c;
      end
    end
  end

  bsa_merge #(.WORD_W(WORD_W)) u_merge (
    .hs_i (s2_hs),
    .cin_i(s2_cin),
    .sum_o(sum_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      res_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      done_q <= s2_vld;
      if (s2_vld) begin
        res_q  <= sum_c;
        flag_q <= s2_cout;
      end
    end
  end

  assign done_o = done_q;
  assign res_o  = res_q;
  assign flag_o = flag_q;

  // cycles since reset, so that depth-3 history lies after reset
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  // R5: done exactly three edges after issue
  a_r5_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (done_o == $past(issue_i, 3)));

  // R2: add result and carry out
  a_r2_add_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) && done_o && $past(issue_i && add_en_i, 3)
    |-> {flag_o, res_o} == $past({1'b0, op_f} + {1'b0, op_t}, 3));

  // R3: subtract result and borrow out
  a_r3_sub_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) && done_o && $past(issue_i && !add_en_i, 3)
    |-> {flag_o, res_o} == $past({1'b0, op_f} - {1'b0, op_t}, 3));

  // R4: increment is one above the false-port word
  a_r4_inc_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) && done_o && $past(issue_i && add_en_i && const_one_i, 3)
    |-> res_o == $past(op_f + ONE, 3));

  // R8: row minus itself is zero, no borrow
  a_r8_self_sub: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) && done_o
    && $past(issue_i && !add_en_i && !const_one_i && (src_f_i == src_t_i), 3)
    |-> (res_o == '0) && !flag_o);
endmodule

// File: tb/bitslice_addsub_tb.sv
module bitslice_addsub_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 8;
  localparam int AW = 4;
  localparam int ROWS = 1 << AW;

  logic          clk, rst_n;
  logic          issue, add_en, one;
  logic [AW-1:0] src_f, src_t, dst;
  logic          ld_en;
  logic [AW-1:0] ld_row, pk_row;
  logic [W-1:0]  ld_data, pk_data, res;
  logic          done, flag;

  bitslice_addsub #(.WORD_W(W), .ADDR_W(AW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .add_en_i(add_en),
    .const_one_i(one), .src_f_i(src_f), .src_t_i(src_t), .dst_i(dst),
    .load_en_i(ld_en), .load_row_i(ld_row), .load_data_i(ld_data),
    .peek_row_i(pk_row), .peek_data_o(pk_data),
    .done_o(done), .res_o(res), .flag_o(flag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int nvec = 0, nbad = 0;
  bit finished = 0;

  logic [W-1:0] mdl [ROWS];
  bit           p_vld [1:3];
  logic [AW-1:0] p_dst [1:3];
  logic [W-1:0] p_res [1:3];
  bit           p_flag [1:3];
  string        p_tag [1:3];
  string        done_tag = "R5";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // expected word and flag from the requirements (R2, R3, R4)
  function automatic logic [W:0] calc(input bit a, input logic [W-1:0] f,
                                      input logic [W-1:0] t);
    if (a) return {1'b0, f} + {1'b0, t};
    else   return {1'b0, f} - {1'b0, t};
  endfunction

  // one clock: entered and left just after a falling edge
  task automatic step(input bit iss, input bit a, input bit o,
                      input logic [AW-1:0] rf, input logic [AW-1:0] rt,
                      input logic [AW-1:0] d, input string tg);
    logic [W:0]   e;
    logic [W-1:0] tv;
    issue = iss; add_en = a; one = o; src_f = rf; src_t = rt; dst = d;
    tv = o ? W'(1) : mdl[rt];
    e  = calc(a, mdl[rf], tv);
    @(posedge clk);
    for (int k = 3; k > 1; k--) begin
      p_vld[k] = p_vld[k-1]; p_dst[k] = p_dst[k-1];
      p_res[k] = p_res[k-1]; p_flag[k] = p_flag[k-1]; p_tag[k] = p_tag[k-1];
    end
    p_vld[1] = iss; p_dst[1] = d; p_res[1] = e[W-1:0]; p_flag[1] = e[W];
    p_tag[1] = tg;
    if (ld_en) mdl[ld_row] = ld_data;
    if (p_vld[3]) mdl[p_dst[3]] = p_res[3];   // R9: write-back kept
    @(negedge clk);
    ld_en = 1'b0;
    chk(done == p_vld[3], done_tag, "done", done, p_vld[3]);
    if (p_vld[3]) begin
      chk(res == p_res[3], p_tag[3], "res", res, p_res[3]);
      chk(flag == p_flag[3], p_tag[3], "flag", flag, p_flag[3]);
    end
    chk(pk_data == mdl[pk_row], "R5", "peek", pk_data, mdl[pk_row]);
  endtask

  task automatic idle();
    step(1'b0, 1'b1, 1'b0, '0, '0, '0, "R5");
  endtask

  task automatic load(input logic [AW-1:0] r, input logic [W-1:0] v);
    ld_en = 1'b1; ld_row = r; ld_data = v;
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nvec++; nbad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5e_a0c3));
    rst_n = 1'b0; issue = 0; add_en = 1; one = 0;
    src_f = '0; src_t = '0; dst = '0;
    ld_en = 0; ld_row = '0; ld_data = '0; pk_row = '0;
    for (int r = 0; r < ROWS; r++) mdl[r] = '0;
    for (int k = 1; k <= 3; k++) begin
      p_vld[k] = 0; p_dst[k] = '0; p_res[k] = '0; p_flag[k] = 0; p_tag[k] = "";
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    for (int r = 0; r < ROWS; r++) begin
      pk_row = AW'(r); #1;
      chk(pk_data == '0, "R1", "row in reset", pk_data, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", done, 0);

    load(4'd0, 8'hFF); load(4'd1, 8'h01); load(4'd2, 8'h00);
    load(4'd3, 8'h80); load(4'd4, 8'h7F); load(4'd5, 8'hA5);
    pk_row = 4'd8;

    // R2: full carry ripple, carry in is 0
    step(1, 1, 0, 4'd0, 4'd1, 4'd8, "R2");
    step(1, 1, 0, 4'd4, 4'd1, 4'd9, "R2");
    step(1, 1, 0, 4'd5, 4'd5, 4'd10, "R2");
    // R3: full borrow ripple, long borrow, none
    step(1, 0, 0, 4'd2, 4'd1, 4'd11, "R3");
    step(1, 0, 0, 4'd3, 4'd4, 4'd12, "R3");
    step(1, 0, 0, 4'd4, 4'd3, 4'd13, "R3");
    // R8: self subtract
    step(1, 0, 0, 4'd5, 4'd5, 4'd14, "R8");
    // R4: increment / decrement with src_t varying (ignored)
    step(1, 1, 1, 4'd0, 4'd5, 4'd15, "R4");
    step(1, 1, 1, 4'd4, 4'd3, 4'd14, "R4");
    step(1, 0, 1, 4'd2, 4'd0, 4'd13, "R4");
    step(1, 0, 1, 4'd3, 4'd4, 4'd12, "R4");
    repeat (3) idle();

    // R7: reads one, two and three edges after a pending write
    load(4'd10, 8'h10); load(4'd11, 8'h05);
    pk_row = 4'd10;
    step(1, 1, 0, 4'd10, 4'd11, 4'd10, "R7");
    step(1, 1, 0, 4'd10, 4'd11, 4'd12, "R7");
    step(1, 1, 0, 4'd10, 4'd11, 4'd13, "R7");
    step(1, 1, 0, 4'd10, 4'd11, 4'd14, "R7");
    repeat (3) idle();

    // R9: load and write-back on the same edge to the same row
    pk_row = 4'd9;
    step(1, 1, 0, 4'd5, 4'd1, 4'd9, "R9");
    idle(); 
    ld_en = 1'b1; ld_row = 4'd9; ld_data = 8'h55;
    idle();
    chk(pk_data == 8'hA6, "R9", "collision row", pk_data, 8'hA6);
    repeat (2) idle();

    // R6: random stream, mostly back-to-back
    done_tag = "R6";
    for (int n = 0; n < 400; n++) begin
      bit iss, a, o;
      logic [AW-1:0] rf, rt, d;
      string tg;
      iss = ($urandom_range(7) != 0);
      a   = $urandom_range(1);
      o   = ($urandom_range(3) == 0);
      rf  = AW'($urandom_range(ROWS-1));
      rt  = AW'($urandom_range(ROWS-1));
      d   = AW'($urandom_range(ROWS-1));
      tg  = o ? "R4" : (a ? "R2" : "R3");
      if ($urandom_range(5) == 0) begin
        ld_en = 1'b1; ld_row = AW'($urandom_range(ROWS-1));
        ld_data = W'($urandom);
      end
      pk_row = AW'($urandom_range(ROWS-1));
      step(iss, a, o, rf, rt, d, tg);
    end
    repeat (4) idle();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule